// File: doc/BRIEF.md
# Legacy Device Access Trap Monitor

This block snoops every cycle on a host bus and decides whether it touched one of the classic fixed PC device address windows: the two disk drive channels, the floppy controller, the printer ports, the video adapter and the keyboard/mouse controller. Each device has one sticky status bit. A matching cycle sets that bit, and it stays set until software writes a 1 to it. Power-management firmware uses the bits to learn which devices have been active, and it can request an interrupt for any subset of them.

The two disk channels each serve a master and a slave drive. The monitor watches writes to each channel's drive/head port and keeps bit 4 of the last value written. A hit on a channel is then credited to the drive that is currently selected. An enable mask is ANDed with the status bits, and the OR of the result drives one registered interrupt line. A small register port reads and writes the status and enable words. Bits that stand for unsupported event sources (6 to 8 and 11 to 19) exist in the layout but are never set by hardware.

Top module: `legacy_trap_mon`

## Requirements
- R1: After a synchronous reset, both registers read 0, `pm_irq` is low and both drive selects are master.
- R2: Reads return 0 in bits 31:20 of both registers (`reg_sel` 0 = status, 1 = enable). Status bits 6 to 8 and 11 to 19 are never set.
- R3: A register write with `reg_sel`=0 clears every status bit whose `reg_wdata` bit is 1. A 0 in `reg_wdata` leaves the bit unchanged. A set status bit stays set until it is cleared this way.
- R4: If a trap and a clear target the same status bit in the same cycle, the bit ends up set.
- R5: `pm_irq` is high one cycle after an edge exactly when status AND enable is nonzero.
- R6: An I/O cycle to 0x1F0–0x1F7 or 0x3F6 sets bit 0 when the primary select is 0 (master) and bit 1 when it is 1 (slave). The primary select is bit 4 of the last I/O write to 0x1F6.
- R7: An I/O cycle to 0x170–0x177 or 0x376 sets bit 2 (master) or bit 3 (slave). The secondary select is bit 4 of the last I/O write to 0x176.
- R8: An I/O write to 0x1F6 or 0x176 updates the select first, so that cycle's own trap goes to the newly selected drive.
- R9: An I/O cycle to 0x3F0–0x3F5, 0x3F7, 0x370–0x375 or 0x377 sets bit 4.
- R10: An I/O cycle to 0x278–0x27F, 0x378–0x37F or 0x3BC–0x3BF sets bit 5. The last range also lies in the video window, so it sets bit 9 as well.
- R11: An I/O cycle to 0x3B0–0x3DF or a memory cycle to 0x0A0000–0x0BFFFF sets bit 9.
- R12: An I/O cycle to 0x60 or 0x64 sets bit 10.
- R13: No trap is taken when `cyc_valid` is low, and no trap is taken when the I/O-versus-memory flag does not match the window type. For example, a memory cycle at 0x60 does not trap, and an I/O cycle at 0xA0000 does not trap.
- R14: A register write with `reg_sel`=1 stores `reg_wdata[19:0]` as the enable mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_valid | input | 1 | Strobe: a host bus cycle is present |
| cyc_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| cyc_write | input | 1 | 1 = write cycle |
| cyc_addr | input | ADDR_W (24) | Cycle address |
| cyc_wdata | input | DATA_W (8) | Cycle write data (drive select snooped from bit 4) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata | input | REG_W (32) | Register write data |
| reg_rdata | output | REG_W (32) | Read data of the selected register |
| pm_irq | output | 1 | Power-management interrupt |

## Verification
Two kinds of event can land on the same edge. The first is a hardware trap and a software write-1-to-clear aimed at the same status bit. The second is a drive-select write together with the classification of that same write. The bench provokes the first by issuing an all-ones status clear in the same cycle as a keyboard-port access; it expects only the keyboard bit to survive. It provokes the second by writing 0x1F6 and 0x176 with bit 4 toggled; it expects the trap to go to the new drive. A behavioural model steps with the design on every clock, including a long stretch of random bus cycles mixed with random register writes. In that stretch both kinds of collision recur.

// File: rtl/trap_pkg.sv
package trap_pkg;
  // status bit positions (software decodes these)
  localparam int unsigned EV_PRI_M  = 0;
  localparam int unsigned EV_PRI_S  = 1;
  localparam int unsigned EV_SEC_M  = 2;
  localparam int unsigned EV_SEC_S  = 3;
  localparam int unsigned EV_FLOPPY = 4;
  localparam int unsigned EV_PRINT  = 5;
  localparam int unsigned EV_VIDEO  = 9;
  localparam int unsigned EV_KBD    = 10;
  // drive/head register ports and the select bit within them
  localparam int unsigned PRI_DH_PORT = 32'h1F6;
  localparam int unsigned SEC_DH_PORT = 32'h176;
  localparam int unsigned DRV_BIT     = 4;
endpackage

// File: rtl/trap_decode.sv
module trap_decode
  import trap_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int NUM_EV = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_valid,
  input  logic              cyc_is_io,
  input  logic              cyc_write,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [DATA_W-1:0] cyc_wdata,
  output logic [NUM_EV-1:0] hit_vec
);
  function automatic logic in_win(input logic [ADDR_W-1:0] a,
                                  input int unsigned lo, input int unsigned hi);
    return (a >= ADDR_W'(lo)) && (a <= ADDR_W'(hi));
  endfunction

  logic pri_q, sec_q;
  logic pri_wr, sec_wr, pri_sel, sec_sel;
  logic io_cyc, mem_cyc, pri_win, sec_win;

  assign io_cyc  = cyc_valid && cyc_is_io;
  assign mem_cyc = cyc_valid && !cyc_is_io;
  assign pri_wr  = io_cyc && cyc_write && (cyc_addr == ADDR_W'(PRI_DH_PORT));
  assign sec_wr  = io_cyc && cyc_write && (cyc_addr == ADDR_W'(SEC_DH_PORT));
  // a select write steers its own cycle
  assign pri_sel = pri_wr ? cyc_wdata[DRV_BIT] : pri_q;
  assign sec_sel = sec_wr ? cyc_wdata[DRV_BIT] : sec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pri_q <= 1'b0;
      sec_q <= 1'b0;
    end else begin
      pri_q <= pri_sel;
      sec_q <= sec_sel;
    end
  end

  assign pri_win = in_win(cyc_addr, 32'h1F0, 32'h1F7) || (cyc_addr == ADDR_W'(32'h3F6));
  assign sec_win = in_win(cyc_addr, 32'h170, 32'h177) || (cyc_addr == ADDR_W'(32'h376));

  always_comb begin
    hit_vec = '0;
    hit_vec[EV_PRI_M]  = io_cyc && pri_win && !pri_sel;
    hit_vec[EV_PRI_S]  = io_cyc && pri_win &&  pri_sel;
    hit_vec[EV_SEC_M]  = io_cyc && sec_win && !sec_sel;
    hit_vec[EV_SEC_S]  = io_cyc && sec_win &&  sec_sel;
    hit_vec[EV_FLOPPY] = io_cyc && (in_win(cyc_addr, 32'h3F0, 32'h3F5) ||
                                    in_win(cyc_addr, 32'h370, 32'h375) ||
                                    cyc_addr == ADDR_W'(32'h3F7) ||
                                    cyc_addr == ADDR_W'(32'h377));
    hit_vec[EV_PRINT]  = io_cyc && (in_win(cyc_addr, 32'h278, 32'h27F) ||
                                    in_win(cyc_addr, 32'h378, 32'h37F) ||
                                    in_win(cyc_addr, 32'h3BC, 32'h3BF));
    hit_vec[EV_VIDEO]  = (io_cyc && in_win(cyc_addr, 32'h3B0, 32'h3DF)) ||
                         (mem_cyc && in_win(cyc_addr, 32'h0A0000, 32'h0BFFFF));
    hit_vec[EV_KBD]    = io_cyc && (cyc_addr == ADDR_W'(32'h60) ||
                                    cyc_addr == ADDR_W'(32'h64));
  end

  logic unused_wdata;
  assign unused_wdata = ^cyc_wdata;

  // R13
  always_comb begin
    if (!cyc_valid) idle_quiet_chk: assert (hit_vec == '0);
  end

  // R6
  pri_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(pri_wr) |-> (pri_q == $past(pri_q)));

  // R7
  sec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(sec_wr) |-> (sec_q == $past(sec_q)));

  // R6
  drive_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec[EV_SEC_S:EV_PRI_M]));
endmodule

// File: rtl/trap_status.sv
module trap_status #(
  parameter int NUM_EV = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EV-1:0] hit_vec,
  input  logic              clr_we,
  input  logic [NUM_EV-1:0] clr_mask,
  input  logic              en_we,
  input  logic [NUM_EV-1:0] en_data,
  output logic [NUM_EV-1:0] st_q,
  output logic [NUM_EV-1:0] en_q,
  output logic              irq_q
);
  logic [NUM_EV-1:0] st_d, en_d;

  for (genvar i = 0; i < NUM_EV; i++) begin : g_bit
    // set has priority over a same-cycle clear
    always_comb begin
      if (hit_vec[i])                st_d[i] = 1'b1;
      else if (clr_we && clr_mask[i]) st_d[i] = 1'b0;
      else                           st_d[i] = st_q[i];
    end
  end

  assign en_d = en_we ? en_data : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      en_q  <= en_d;
      irq_q <= |(st_d & en_d);
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (st_q == '0 && en_q == '0 && !irq_q));

  // R3
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> ((st_q & $past(st_q)) == $past(st_q)));

  // R3
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((st_q & $past(clr_mask & ~hit_vec)) == '0));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|hit_vec) |=> ((st_q & $past(hit_vec)) == $past(hit_vec)));

  // R5
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ((st_q & en_q) != '0));

  // R5
  irq_needed_chk: assert property (@(posedge clk) disable iff (rst)
    ((st_q & en_q) != '0) |-> irq_q);
endmodule

// File: rtl/legacy_trap_mon.sv
module legacy_trap_mon #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int REG_W  = 32,
  parameter int NUM_EV = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_valid,
  input  logic              cyc_is_io,
  input  logic              cyc_write,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [DATA_W-1:0] cyc_wdata,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              pm_irq
);
  localparam int PAD_W = REG_W - NUM_EV;

  logic [NUM_EV-1:0] hit_vec, st_q, en_q;
  logic clr_we, en_we;

  assign clr_we = reg_wr && !reg_sel;
  assign en_we  = reg_wr &&  reg_sel;

  trap_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_EV(NUM_EV)) u_dec (
    .clk(clk), .rst(rst),
    .cyc_valid(cyc_valid), .cyc_is_io(cyc_is_io), .cyc_write(cyc_write),
    .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata),
    .hit_vec(hit_vec)
  );

  trap_status #(.NUM_EV(NUM_EV)) u_st (
    .clk(clk), .rst(rst),
    .hit_vec(hit_vec),
    .clr_we(clr_we), .clr_mask(reg_wdata[NUM_EV-1:0]),
    .en_we(en_we), .en_data(reg_wdata[NUM_EV-1:0]),
    .st_q(st_q), .en_q(en_q), .irq_q(pm_irq)
  );

  assign reg_rdata = {{PAD_W{1'b0}}, (reg_sel ? en_q : st_q)};

  logic unused_upper;
  assign unused_upper = ^reg_wdata;

  // R2
  always_comb begin
    if (!rst) reserved_zero_chk: assert (reg_rdata[REG_W-1:NUM_EV] == '0);
  end
endmodule

// File: tb/sim_legacy_trap_mon.sv
module sim_legacy_trap_mon;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_valid = 1'b0, cyc_is_io = 1'b0, cyc_write = 1'b0;
  logic [23:0] cyc_addr = '0;
  logic [7:0]  cyc_wdata = '0;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic pm_irq;

  int vectors = 0, errors = 0;
  bit done = 0;
  // reference state
  int unsigned m_st = 0, m_en = 0;
  bit m_pri = 0, m_sec = 0, m_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  legacy_trap_mon u0 (
    .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .cyc_is_io(cyc_is_io),
    .cyc_write(cyc_write), .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pm_irq(pm_irq)
  );

  function automatic bit between(int unsigned a, int unsigned lo, int unsigned hi);
    return a >= lo && a <= hi;
  endfunction

  function automatic int unsigned ref_hits(bit v, bit io, int unsigned a, bit ps, bit ss);
    int unsigned h = 0;
    if (!v) return 0;
    if (io) begin
      if (between(a, 'h1F0, 'h1F7) || a == 'h3F6) h |= ps ? 32'h2 : 32'h1;
      if (between(a, 'h170, 'h177) || a == 'h376) h |= ss ? 32'h8 : 32'h4;
      if (between(a, 'h3F0, 'h3F5) || between(a, 'h370, 'h375) || a == 'h3F7 || a == 'h377)
        h |= 32'h10;
      if (between(a, 'h278, 'h27F) || between(a, 'h378, 'h37F) || between(a, 'h3BC, 'h3BF))
        h |= 32'h20;
      if (between(a, 'h3B0, 'h3DF)) h |= 32'h200;
      if (a == 'h60 || a == 'h64) h |= 32'h400;
    end else if (between(a, 'hA0000, 'hBFFFF)) h |= 32'h200;
    return h;
  endfunction

  task automatic ref_edge();
    int unsigned h;
    if (rst) begin
      m_st = 0; m_en = 0; m_pri = 0; m_sec = 0; m_irq = 0;
      return;
    end
    if (cyc_valid && cyc_is_io && cyc_write && cyc_addr == 24'h1F6) m_pri = cyc_wdata[4];
    if (cyc_valid && cyc_is_io && cyc_write && cyc_addr == 24'h176) m_sec = cyc_wdata[4];
    h = ref_hits(cyc_valid, cyc_is_io, cyc_addr, m_pri, m_sec);
    if (reg_wr && !reg_sel) m_st = m_st & ~reg_wdata;
    if (reg_wr && reg_sel)  m_en = reg_wdata & 32'hFFFFF;
    m_st = (m_st | h) & 32'hFFFFF;
    m_irq = (m_st & m_en) != 0;
  endtask

  task automatic chk(int unsigned act, int unsigned exp, string tag);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // drive one cycle, advance, compare with the model
  task automatic step(bit v, bit io, bit w, int unsigned a, int unsigned d,
                      bit rw, bit rs, int unsigned rd, string tag);
    cyc_valid = v; cyc_is_io = io; cyc_write = w; cyc_addr = a[23:0]; cyc_wdata = d[7:0];
    reg_wr = rw; reg_sel = rs; reg_wdata = rd;
    @(posedge clk);
    ref_edge();
    @(negedge clk);
    cyc_valid = 0; reg_wr = 0;
    chk(reg_rdata, rs ? m_en : m_st, {tag, " rdata"});
    chk(pm_irq, m_irq, {tag, " irq"});
  endtask

  task automatic io(int unsigned a, string tag);
    step(1, 1, 0, a, 0, 0, 0, 0, tag);
  endtask

  task automatic clear_all();
    step(0, 0, 0, 0, 0, 1, 0, 32'hFFFFFFFF, "R3 clear");
  endtask

  task automatic read_status(int unsigned exp, string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, tag);
    chk(reg_rdata, exp, {tag, " fixed"});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    ref_edge();
    @(negedge clk);
    chk(reg_rdata, 0, "R1 status after reset");
    chk(pm_irq, 0, "R1 irq after reset");
    rst = 0;
    step(0, 0, 0, 0, 0, 0, 1, 0, "R1 enable after reset");
    chk(reg_rdata, 0, "R1 enable zero");

    // R14 and R2: enable storage and reserved bits
    step(0, 0, 0, 0, 0, 1, 1, 32'hFFFFFFFF, "R14 enable write");
    chk(reg_rdata, 32'h000FFFFF, "R2 enable reserved zero");

    // R6 primary channel, master after reset
    io('h1F0, "R6 primary master");
    chk(reg_rdata, 32'h1, "R6 bit0");
    chk(pm_irq, 1, "R5 irq on enabled bit");
    // R8 write select slave: own cycle goes to slave
    step(1, 1, 1, 'h1F6, 'h10, 0, 0, 0, "R8 primary select write");
    chk(reg_rdata, 32'h3, "R8 slave credited same cycle");
    clear_all();
    io('h3F6, "R6 primary slave control port");
    read_status(32'h2, "R6 bit1");
    // R3: writing zeros leaves bits
    step(0, 0, 0, 0, 0, 1, 0, 32'hFFFFFFFD, "R3 zero keeps");
    chk(reg_rdata, 32'h2, "R3 zero bit keeps status");
    clear_all();
    chk(reg_rdata, 0, "R3 cleared");
    chk(pm_irq, 0, "R5 irq drops");

    // R7 secondary
    io('h177, "R7 secondary master");
    chk(reg_rdata, 32'h4, "R7 bit2");
    step(1, 1, 1, 'h176, 'hFF, 0, 0, 0, "R8 secondary select slave");
    chk(reg_rdata, 32'hC, "R8 bit3 same cycle");
    step(1, 1, 1, 'h176, 'hEF, 1, 0, 32'hC, "R8 secondary back to master");
    chk(reg_rdata, 32'h4, "R8 master credited, clear of bit3");
    clear_all();

    // R9 floppy, R10 printer, R11 video, R12 keyboard
    io('h3F2, "R9 floppy 3F2"); io('h377, "R9 floppy 377");
    read_status(32'h10, "R9 bit4");
    clear_all();
    io('h278, "R10 printer 278");
    read_status(32'h20, "R10 bit5");
    io('h3BD, "R10 printer in video window");
    read_status(32'h220, "R10 bits5 and 9");
    clear_all();
    step(1, 0, 0, 'hB8000, 0, 0, 0, 0, "R11 video memory");
    read_status(32'h200, "R11 bit9 memory");
    clear_all();
    io('h3D4, "R11 video io");
    read_status(32'h200, "R11 bit9 io");
    clear_all();
    io('h64, "R12 keyboard 64");
    read_status(32'h400, "R12 bit10");
    clear_all();

    // R13 mismatched space and idle strobe
    step(1, 0, 1, 'h60, 0, 0, 0, 0, "R13 memory at 60");
    step(1, 1, 0, 'hA0000, 0, 0, 0, 0, "R13 io at A0000");
    step(0, 1, 0, 'h1F0, 0, 0, 0, 0, "R13 strobe low");
    read_status(0, "R13 no trap");

    // R4 set wins over clear
    io('h3F0, "R4 prep");
    step(1, 1, 0, 'h60, 0, 1, 0, 32'hFFFFFFFF, "R4 clear with trap");
    chk(reg_rdata, 32'h400, "R4 set wins");
    step(1, 1, 0, 'h60, 0, 1, 0, 32'h400, "R4 same bit");
    chk(reg_rdata, 32'h400, "R4 same bit survives");

    // R5 masking
    step(0, 0, 0, 0, 0, 1, 1, 32'h10, "R14 enable floppy only");
    chk(pm_irq, 0, "R5 masked bit no irq");
    io('h375, "R5 floppy enabled");
    chk(pm_irq, 1, "R5 irq from floppy");

    // random mix: collisions of traps, clears and select writes
    for (int i = 0; i < 2000; i++) begin
      int unsigned pool [12] = '{'h1F0, 'h1F6, 'h3F6, 'h170, 'h176, 'h3F7,
                                 'h37A, 'h3BE, 'h3C8, 'h64, 'hA1234, 'h2F8};
      int unsigned a = pool[$urandom_range(0, 11)];
      step($urandom_range(0, 3) != 0, $urandom_range(0, 4) != 0, $urandom_range(0, 1),
           a, $urandom, $urandom_range(0, 3) == 0, $urandom_range(0, 1), $urandom,
           "R2/R3/R4/R5/R8 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule